// File: doc/BRIEF.md
# Nonvolatile Shadow-Memory Store Controller

This block is the control logic for a byte-wide static memory that carries a nonvolatile shadow copy of every cell. It turns active-low chip-enable, output-enable and write-enable strobes into read and write enables for the array. It tracks whether the array holds data not yet saved. It also sequences the two bulk transfers: a copy into the shadow (STORE) and a copy back from it (RECALL).

A STORE can be asked for in three ways. The first is an external agent pulling the shared active-low busy/request line. The second is a supply monitor reporting a low supply while power-fail saving is enabled. The third is a one-cycle software request pulse. The busy line is open drain. The block senses it on `busy_in` and drives it through two enables, one for low and one for high, and the board resolves the wire against a weak pull-up. All strobes are sampled on `clk`, and the host holds the address steady for the whole of a cycle.

Top module: `nvshadow_ctl`

## Requirements
- R1: `rd_en` is high only in the idle phase, with `ce_n`=0, `oe_n`=0, `we_n`=1 and `busy_in`=1.
- R2: `wr_en` is high only with `ce_n`=0 and `we_n`=0. A write may start only in the idle phase with `busy_in`=1. A write stays enabled while both strobes remain low.
- R3: `dirty` is set on the clock after any cycle with `wr_en`=1. It is cleared at the end of every STORE and every RECALL.
- R4: In idle, the requests are taken in a fixed priority order. A `sw_store` pulse starts a STORE whatever the state of `dirty`. A low `busy_in` starts one only if `dirty`=1. The power-fail input starts one only if `dirty`=1.
- R5: `busy_drv_lo` is high throughout the hold window and the STORE itself.
- R6: A write already running when the line falls may continue through the hold window, which lasts DELAY_CYC cycles. A write that starts after the line falls gets no `wr_en` until the block is idle with the line high again.
- R7: If `busy_in` is low from outside while `dirty`=0, the block starts no STORE and drives neither `busy_drv_lo` nor `busy_drv_hi`. Reads are refused while the line stays low.
- R8: After a STORE started by software or by the line, `busy_drv_hi` is high for HI_CYC cycles and then released. A power-fail STORE returns straight to idle with no high drive.
- R9: A power-fail STORE needs `pwr_low`=1 and `pf_en`=1 together. With `pf_en`=0 a low supply starts nothing.
- R10: After reset, RECALL runs for RECALL_CYC cycles with `recall_act`=1, and `rd_en` and `wr_en` stay low during it.
- R11: `store_act` is high for exactly STORE_CYC cycles per STORE, following a hold window of DELAY_CYC cycles.
- R12: Requests that arrive while a STORE or RECALL is running are dropped and do not start a second STORE afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; RECALL starts on release |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy_in | input | 1 | Sensed level of the open-drain busy/request line |
| sw_store | input | 1 | One-cycle software STORE request |
| pwr_low | input | 1 | Supply monitor: supply below switch threshold |
| pf_en | input | 1 | Power-fail saving enabled |
| rd_en | output | 1 | Array read enable |
| wr_en | output | 1 | Array write enable |
| busy_drv_lo | output | 1 | Pull the busy line low |
| busy_drv_hi | output | 1 | Drive the busy line high |
| store_act | output | 1 | Copy into the shadow in progress |
| recall_act | output | 1 | Copy from the shadow in progress |
| dirty | output | 1 | Array changed since last STORE or RECALL |

## Verification
The assertions assume the busy line is resolved correctly from the two drive enables, an external pull-down and the pull-up. They also assume an outside agent never pulls the line low while the block is driving it high. The stimulus keeps to this by holding the external pull-down only for short pulses that end before any STORE finishes. It also holds the strobes constant between clock edges, since the block samples them synchronously.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [2:0] {
      PH_RECALL  = 3'd0,
      PH_IDLE    = 3'd1,
      PH_HOLD    = 3'd2,
      PH_COPY    = 3'd3,
      PH_RELEASE = 3'd4
   } nvs_phase_t;

   typedef enum logic [1:0] {
      SRC_SW = 2'd0,
      SRC_HW = 2'd1,
      SRC_PF = 2'd2
   } nvs_src_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction
endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
   parameter int CW      = 4,
   parameter int RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= CW'(RST_VAL);
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/nvs_access.sv
module nvs_access (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic busy_in,
   input  logic idle,
   input  logic hold,
   output logic rd_en,
   output logic wr_en
);
   logic wr_cont_q;
   logic new_ok;
   logic cont_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_cont_q <= 1'b0;
      else        wr_cont_q <= wr_en;
   end

   always_comb begin
      new_ok  = idle & busy_in;
      cont_ok = (idle | hold) & wr_cont_q;
      wr_en   = ~ce_n & ~we_n & (new_ok | cont_ok);
      rd_en   = idle & ~ce_n & ~oe_n & we_n & busy_in;
   end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
   import nvs_pkg::*;
#(
   parameter int DELAY_CYC  = 4,
   parameter int STORE_CYC  = 16,
   parameter int RECALL_CYC = 16,
   parameter int HI_CYC     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy_in,
   input  logic       sw_store,
   input  logic       pf_fire,
   input  logic       wr_en,
   output nvs_phase_t phase,
   output logic       dirty
);
   localparam int MAXLEN = max3(max3(DELAY_CYC, STORE_CYC, RECALL_CYC), HI_CYC, 1);
   localparam int CW     = $clog2(MAXLEN + 1);
   localparam logic [CW-1:0] LD_HOLD = CW'(DELAY_CYC - 1);
   localparam logic [CW-1:0] LD_COPY = CW'(STORE_CYC - 1);
   localparam logic [CW-1:0] LD_REL  = CW'((HI_CYC > 0) ? HI_CYC - 1 : 0);
   localparam bit HAS_REL = (HI_CYC > 0);

   nvs_phase_t phase_q, phase_d;
   nvs_src_t   src_q, src_d;
   logic       dirty_q;
   logic       tz;
   logic       load;
   logic [CW-1:0] load_val;
   nvs_phase_t after_copy;

   nvs_timer #(.CW(CW), .RST_VAL(RECALL_CYC - 1)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .zero     (tz)
   );

   generate
      if (HAS_REL) begin : g_rel
         assign after_copy = (src_q == SRC_PF) ? PH_IDLE : PH_RELEASE;
      end else begin : g_norel
         assign after_copy = PH_IDLE;
      end
   endgenerate

   always_comb begin
      phase_d = phase_q;
      src_d   = src_q;
      unique case (phase_q)
         PH_RECALL:  if (tz) phase_d = PH_IDLE;
         PH_IDLE: begin
            if (sw_store) begin
               phase_d = PH_HOLD; src_d = SRC_SW;
            end else if (!busy_in && dirty_q) begin
               phase_d = PH_HOLD; src_d = SRC_HW;
            end else if (pf_fire && dirty_q) begin
               phase_d = PH_HOLD; src_d = SRC_PF;
            end
         end
         PH_HOLD:    if (tz) phase_d = PH_COPY;
         PH_COPY:    if (tz) phase_d = after_copy;
         PH_RELEASE: if (tz) phase_d = PH_IDLE;
         default:    phase_d = PH_IDLE;
      endcase
   end

   always_comb begin
      load = (phase_d != phase_q);
      unique case (phase_d)
         PH_HOLD:    load_val = LD_HOLD;
         PH_COPY:    load_val = LD_COPY;
         PH_RELEASE: load_val = LD_REL;
         default:    load_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_RECALL;
         src_q   <= SRC_SW;
         dirty_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         src_q   <= src_d;
         if (wr_en)
            dirty_q <= 1'b1;
         else if (tz && (phase_q == PH_COPY || phase_q == PH_RECALL))
            dirty_q <= 1'b0;
      end
   end

   assign phase = phase_q;
   assign dirty = dirty_q;
endmodule

// File: rtl/nvshadow_ctl.sv
module nvshadow_ctl
   import nvs_pkg::*;
#(
   parameter int DELAY_CYC  = 4,
   parameter int STORE_CYC  = 16,
   parameter int RECALL_CYC = 16,
   parameter int HI_CYC     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic busy_in,
   input  logic sw_store,
   input  logic pwr_low,
   input  logic pf_en,
   output logic rd_en,
   output logic wr_en,
   output logic busy_drv_lo,
   output logic busy_drv_hi,
   output logic store_act,
   output logic recall_act,
   output logic dirty
);
   generate
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("DELAY_CYC must be at least 1");
      end
      if (STORE_CYC < 1) begin : g_bad_store
         $error("STORE_CYC must be at least 1");
      end
      if (RECALL_CYC < 1) begin : g_bad_recall
         $error("RECALL_CYC must be at least 1");
      end
      if (HI_CYC < 0) begin : g_bad_hi
         $error("HI_CYC must not be negative");
      end
   endgenerate

   nvs_phase_t phase;
   logic       pf_fire;
   logic       idle;
   logic       hold;

   assign pf_fire = pwr_low & pf_en;
   assign idle    = (phase == PH_IDLE);
   assign hold    = (phase == PH_HOLD);

   nvs_seq #(
      .DELAY_CYC  (DELAY_CYC),
      .STORE_CYC  (STORE_CYC),
      .RECALL_CYC (RECALL_CYC),
      .HI_CYC     (HI_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy_in  (busy_in),
      .sw_store (sw_store),
      .pf_fire  (pf_fire),
      .wr_en    (wr_en),
      .phase    (phase),
      .dirty    (dirty)
   );

   nvs_access u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n),
      .oe_n    (oe_n),
      .we_n    (we_n),
      .busy_in (busy_in),
      .idle    (idle),
      .hold    (hold),
      .rd_en   (rd_en),
      .wr_en   (wr_en)
   );

   assign busy_drv_lo = (phase == PH_HOLD) || (phase == PH_COPY);
   assign busy_drv_hi = (phase == PH_RELEASE);
   assign store_act   = (phase == PH_COPY);
   assign recall_act  = (phase == PH_RECALL);
endmodule

// File: rtl/nvshadow_ctl_chk.sv
module nvshadow_ctl_chk (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic we_n,
   input logic busy_in,
   input logic rd_en,
   input logic wr_en,
   input logic busy_drv_lo,
   input logic busy_drv_hi,
   input logic store_act,
   input logic recall_act,
   input logic dirty
);
   // R1
   rd_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (!busy_drv_lo && !recall_act && !store_act));

   // R2
   wr_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!ce_n && !we_n));

   // R6
   new_wr_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !$past(wr_en)) |-> busy_in);

   // R3
   store_cleans_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(store_act) |-> !dirty);

   // R5
   store_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_act |-> busy_drv_lo);

   // R8
   no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_drv_lo && busy_drv_hi));

   // R10
   recall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recall_act |-> (!rd_en && !wr_en));
endmodule

bind nvshadow_ctl nvshadow_ctl_chk u_chk (.*);

// File: tb/nvshadow_ctl_test.sv
module nvshadow_ctl_test;
   localparam int DLY = 3;
   localparam int STC = 6;
   localparam int RCC = 5;
   localparam int HIC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic sw_store = 1'b0, pwr_low = 1'b0, pf_en = 1'b0;
   logic ext_low = 1'b0;
   logic busy_line;
   logic rd_en, wr_en, busy_drv_lo, busy_drv_hi, store_act, recall_act, dirty;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int starts = 0;
   int st_cycles = 0;
   logic prev_st = 1'b0;

   // model state: 0 recall, 1 idle, 2 hold, 3 copy, 4 release
   int  m_ph = 0;
   int  m_left = RCC - 1;
   int  m_src = 0;
   bit  m_dirty = 0;
   bit  m_wc = 0;

   always #5 clk = ~clk;

   assign busy_line = busy_drv_lo ? 1'b0 : (busy_drv_hi ? 1'b1 : (ext_low ? 1'b0 : 1'b1));

   nvshadow_ctl #(.DELAY_CYC(DLY), .STORE_CYC(STC), .RECALL_CYC(RCC), .HI_CYC(HIC)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .busy_in(busy_line), .sw_store(sw_store), .pwr_low(pwr_low), .pf_en(pf_en),
      .rd_en(rd_en), .wr_en(wr_en), .busy_drv_lo(busy_drv_lo), .busy_drv_hi(busy_drv_hi),
      .store_act(store_act), .recall_act(recall_act), .dirty(dirty)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, got, exp);
      end
   endtask

   function automatic bit exp_wr();
      return !ce_n && !we_n && ((m_ph == 1 && busy_line) || ((m_ph == 1 || m_ph == 2) && m_wc));
   endfunction

   function automatic bit exp_rd();
      return m_ph == 1 && !ce_n && !oe_n && we_n && busy_line;
   endfunction

   // reference model, advanced on every clock
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_ph = 0; m_left = RCC - 1; m_dirty = 0; m_wc = 0; m_src = 0;
      end else begin
         bit w;
         bit clean_now;
         w = exp_wr();
         clean_now = 0;
         if (m_ph == 1) begin
            if (sw_store) begin
               m_ph = 2; m_left = DLY - 1; m_src = 0;
            end else if (!busy_line && m_dirty) begin
               m_ph = 2; m_left = DLY - 1; m_src = 1;
            end else if (pwr_low && pf_en && m_dirty) begin
               m_ph = 2; m_left = DLY - 1; m_src = 2;
            end
         end else if (m_left > 0) begin
            m_left--;
         end else begin
            case (m_ph)
               0: begin m_ph = 1; clean_now = 1; end
               2: begin m_ph = 3; m_left = STC - 1; end
               3: begin
                  clean_now = 1;
                  if (m_src == 2 || HIC == 0) m_ph = 1;
                  else begin m_ph = 4; m_left = HIC - 1; end
               end
               default: m_ph = 1;
            endcase
         end
         if (w) m_dirty = 1;
         else if (clean_now) m_dirty = 0;
         m_wc = w;
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 rd_en", rd_en, exp_rd());
         chk("R2/R6 wr_en", wr_en, exp_wr());
         chk("R3 dirty", dirty, m_dirty);
         chk("R5 busy_drv_lo", busy_drv_lo, (m_ph == 2 || m_ph == 3));
         chk("R8 busy_drv_hi", busy_drv_hi, (m_ph == 4));
         chk("R11 store_act", store_act, (m_ph == 3));
         chk("R10 recall_act", recall_act, (m_ph == 0));
         if (store_act && !prev_st) starts++;
         if (store_act) st_cycles++;
         prev_st = store_act;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic idle_bus();
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int s0;
      int c0;
      // reset state
      step(2);
      @(negedge clk);
      chk("R10 reset recall_act", recall_act, 1);
      chk("R10 reset no drive", busy_drv_lo | busy_drv_hi, 0);
      #1;
      ce_n = 1'b0; oe_n = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 read held off during recall", rd_en, 0);
      step(RCC + 1);
      @(negedge clk);
      chk("R1 read after recall", rd_en, 1);
      #1;

      // plain writes and reads
      idle_bus();
      step(1);
      ce_n = 1'b0; we_n = 1'b0;
      step(2);
      we_n = 1'b1; oe_n = 1'b0;
      step(2);
      @(negedge clk);
      chk("R3 dirty after write", dirty, 1);
      #1;
      idle_bus();
      step(1);

      // R6: write underway, then external line pulse
      ce_n = 1'b0; we_n = 1'b0;
      step(1);
      ext_low = 1'b1;
      step(2);
      ext_low = 1'b0;
      we_n = 1'b1;
      step(1);
      we_n = 1'b0;
      step(2);
      @(negedge clk);
      chk("R6 late write blocked", wr_en, 0);
      #1;
      idle_bus();
      step(STC + HIC + 2);
      @(negedge clk);
      chk("R4 line request stored", starts, 1);
      chk("R3 clean after store", dirty, 0);
      #1;

      // R7: external low with clean array
      ext_low = 1'b1;
      ce_n = 1'b0; oe_n = 1'b0;
      step(5);
      @(negedge clk);
      chk("R7 read refused", rd_en, 0);
      chk("R7 no drive", busy_drv_lo | busy_drv_hi, 0);
      chk("R7 no store", starts, 1);
      #1;
      ext_low = 1'b0;
      idle_bus();
      step(2);

      // R4/R12: software store with clean array, extra requests ignored
      s0 = st_cycles;
      sw_store = 1'b1;
      step(1);
      sw_store = 1'b0;
      step(DLY + 1);
      sw_store = 1'b1; pf_en = 1'b1; pwr_low = 1'b1;
      step(1);
      sw_store = 1'b0;
      step(STC + HIC + 4);
      pwr_low = 1'b0;
      @(negedge clk);
      chk("R4 software store runs clean", starts, 2);
      chk("R11 store length", st_cycles - s0, STC);
      chk("R12 no second store", store_act, 0);
      #1;

      // R9: power-fail with saving disabled, then enabled
      pf_en = 1'b0;
      ce_n = 1'b0; we_n = 1'b0;
      step(1);
      idle_bus();
      pwr_low = 1'b1;
      step(6);
      @(negedge clk);
      chk("R9 disabled no store", starts, 2);
      #1;
      pf_en = 1'b1;
      c0 = 0;
      for (int i = 0; i < DLY + STC + 4; i++) begin
         @(negedge clk);
         if (busy_drv_hi) c0++;
      end
      #1;
      chk("R9 power-fail store", starts, 3);
      chk("R8 no high drive after power-fail", c0, 0);
      pwr_low = 1'b0;
      step(3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule